// File: doc/BRIEF.md
# Dual-Latch Output Compare Unit

This block turns two free-running 16-bit down-counters into waveforms on a set of output pins. Four identical channels each watch one of the two counts, picked per channel. Each channel has two active compare values. When the watched count equals the first value, the channel's internal level goes high. When it equals the second value, the level goes low. The level, optionally inverted, drives the channel's pin. Every match also sets a sticky per-channel flag, which software clears.

Software loads the compare values one at a time through a write port. A small pointer on that port names the channel and the latch. Each written value first lands in a staging register. It moves into the active latch at once if the channel's timer is stopped or the channel is set for direct loading. Otherwise it waits for the underflow strobe of that timer, so a running waveform never mixes old and new values within one period. A fifth output combines channel 0 and channel 1: the carrier is gated by the envelope.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, every staging and active compare value is 0, every channel level is low, and every match flag is 0. An enabled channel whose timer reads 0 therefore matches in the first cycle.
- R2: A write with `wr_en` high addresses one value. Channel `wr_ptr[2:1]` is selected, and `wr_ptr[0]` picks the high-setting value (0) or the low-setting value (1). No other value changes.
- R3: If the channel's selected timer is stopped, or its `ch_buffered` bit is 0, a write reaches the active value at the same clock edge that loads the staging register.
- R4: If the selected timer is running and `ch_buffered` is 1, a write changes only the staging register. Both staging values are copied to the active values at the edge where the selected timer's underflow strobe is high. If a value is written in that same cycle, the copy uses the staging content from before the write.
- R5: `ch_use_b` = 0 makes a channel compare against timer A's count, running flag and underflow strobe. A value of 1 selects timer B's.
- R6: While a channel is enabled, a clock edge at which the selected count equals the high-setting value makes the level 1. Equality with the low-setting value makes it 0. If both are equal, the level becomes 1. The pin shows the new level from the following cycle.
- R7: While a channel is enabled, its pin equals the level when `ch_invert` is 0, and the complement of the level when `ch_invert` is 1.
- R8: While a channel is disabled, its pin follows `port_level` for that channel, and its level and flag are forced to 0 at each edge.
- R9: An enabled channel sets its flag at any edge with a match on either value. The flag stays set until an edge with the channel's `flag_clear` bit high and no match. A match in the same cycle as a clear wins.
- R10: `mod_pin` is the AND of the channel 0 pin and the channel 1 pin, each after inversion or port substitution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Compare value write strobe |
| wr_ptr | input | 3 | Target of the write: channel in bits 2:1, value select in bit 0 |
| wr_data | input | 16 | Value to write |
| ch_enable | input | 4 | Per-channel enable |
| ch_use_b | input | 4 | Per-channel timer select (0 = A, 1 = B) |
| ch_invert | input | 4 | Per-channel output inversion |
| ch_buffered | input | 4 | Per-channel deferred loading while the timer runs |
| port_level | input | 4 | Pin value used while a channel is disabled |
| tmr_a_count | input | 16 | Current count of timer A |
| tmr_a_running | input | 1 | Timer A is counting |
| tmr_a_wrap | input | 1 | Timer A underflow strobe |
| tmr_b_count | input | 16 | Current count of timer B |
| tmr_b_running | input | 1 | Timer B is counting |
| tmr_b_wrap | input | 1 | Timer B underflow strobe |
| flag_clear | input | 4 | Per-channel flag clear |
| cmp_pin | output | 4 | Per-channel waveform pins |
| match_flag | output | 4 | Per-channel sticky match flags |
| mod_pin | output | 1 | Channel 0 carrier gated by channel 1 |

## Verification
The bench looks for the cases where loading goes wrong. One is a write landing in the same cycle as an underflow strobe: a design that copied the new word early would tear a period. Another is a channel switching timers while writes wait in staging, which a design tracking the wrong strobe would reload at the wrong time. It also checks that both values match at once and that a clear collides with a match, where a swapped priority shows up as a low level or a lost flag. Finally, it disables a channel in mid-waveform: a design that kept its level would resume with a stale high pin when the channel is enabled again.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

    localparam int OCMP_LATCHES = 2;

    typedef struct packed {
        logic en;
        logic use_b;
        logic invert;
        logic buffered;
    } ch_cfg_t;

    function automatic logic pin_value(input logic en, input logic level,
                                       input logic invert, input logic port);
        return en ? (level ^ invert) : port;
    endfunction

endpackage

// File: rtl/ocmp_wr_decode.sv
module ocmp_wr_decode #(
    parameter int NCH   = 4,
    parameter int PTR_W = $clog2(NCH) + 1
) (
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_ptr,
    output logic [NCH-1:0][1:0]   wr_hit
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar k = 0; k < 2; k++) begin : g_sel
            assign wr_hit[c][k] = wr_en
                && (wr_ptr[PTR_W-1:1] == (PTR_W-1)'(c))
                && (wr_ptr[0] == 1'(k));
        end
    end
endmodule

// File: rtl/ocmp_modulator.sv
module ocmp_modulator (
    input  logic carrier,
    input  logic envelope,
    output logic mod_out
);
    assign mod_out = carrier & envelope;
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_cfg_t       cfg,
    input  logic          port_level,
    input  logic [1:0]    wr_hit,
    input  logic [CW-1:0] wr_data,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    input  logic          run_a,
    input  logic          run_b,
    input  logic          wrap_a,
    input  logic          wrap_b,
    input  logic          flag_clear,
    output logic          pin,
    output logic          flag
);
    logic [CW-1:0] stage_q  [OCMP_LATCHES];
    logic [CW-1:0] active_q [OCMP_LATCHES];
    logic [1:0]    hit;
    logic [CW-1:0] cnt_sel;
    logic          run_sel;
    logic          wrap_sel;
    logic          load_now;
    logic          level_q;
    logic          flag_q;

    assign cnt_sel  = cfg.use_b ? cnt_b  : cnt_a;
    assign run_sel  = cfg.use_b ? run_b  : run_a;
    assign wrap_sel = cfg.use_b ? wrap_b : wrap_a;
    assign load_now = !run_sel || !cfg.buffered;

    always_ff @(posedge clk) begin
        for (int k = 0; k < OCMP_LATCHES; k++) begin
            if (rst) begin
                stage_q[k]  <= '0;
                active_q[k] <= '0;
            end else begin
                if (wr_hit[k]) stage_q[k] <= wr_data;
                if (wr_hit[k] && load_now) active_q[k] <= wr_data;
                else if (wrap_sel)         active_q[k] <= stage_q[k];
            end
        end
    end

    for (genvar k = 0; k < OCMP_LATCHES; k++) begin : g_cmp
        assign hit[k] = (cnt_sel == active_q[k]);

        // R3: direct load lands on the same edge
        assert_direct_load_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_hit[k] && load_now) |=> (active_q[k] == $past(wr_data)));

        // R4: active value only moves on a write-through or an underflow
        assert_hold_until_wrap_R4: assert property (@(posedge clk) disable iff (rst)
            (!wrap_sel && !(wr_hit[k] && load_now)) |=> $stable(active_q[k]));
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg.en) begin
            level_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (hit[0])      level_q <= 1'b1;
            else if (hit[1]) level_q <= 1'b0;
            if (|hit)            flag_q <= 1'b1;
            else if (flag_clear) flag_q <= 1'b0;
        end
    end

    assign pin  = pin_value(cfg.en, level_q, cfg.invert, port_level);
    assign flag = flag_q;

    assert_rise_on_high_value_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && hit[0]) |=> level_q);

    assert_fall_on_low_value_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && hit[1] && !hit[0]) |=> !level_q);

    assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (!flag_q && !level_q));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && flag_q && !flag_clear) |=> flag_q);

    assert_flag_on_match_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && (|hit)) |=> flag_q);
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
    import ocmp_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CW    = 16,
    parameter int PTR_W = $clog2(NCH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [CW-1:0]    wr_data,
    input  logic [NCH-1:0]   ch_enable,
    input  logic [NCH-1:0]   ch_use_b,
    input  logic [NCH-1:0]   ch_invert,
    input  logic [NCH-1:0]   ch_buffered,
    input  logic [NCH-1:0]   port_level,
    input  logic [CW-1:0]    tmr_a_count,
    input  logic             tmr_a_running,
    input  logic             tmr_a_wrap,
    input  logic [CW-1:0]    tmr_b_count,
    input  logic             tmr_b_running,
    input  logic             tmr_b_wrap,
    input  logic [NCH-1:0]   flag_clear,
    output logic [NCH-1:0]   cmp_pin,
    output logic [NCH-1:0]   match_flag,
    output logic             mod_pin
);
    logic [NCH-1:0][1:0] wr_hit;

    ocmp_wr_decode #(.NCH(NCH), .PTR_W(PTR_W)) u_decode (
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr),
        .wr_hit (wr_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        ch_cfg_t cfg;
        assign cfg = '{en: ch_enable[c], use_b: ch_use_b[c],
                       invert: ch_invert[c], buffered: ch_buffered[c]};

        ocmp_channel #(.CW(CW)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .cfg        (cfg),
            .port_level (port_level[c]),
            .wr_hit     (wr_hit[c]),
            .wr_data    (wr_data),
            .cnt_a      (tmr_a_count),
            .cnt_b      (tmr_b_count),
            .run_a      (tmr_a_running),
            .run_b      (tmr_b_running),
            .wrap_a     (tmr_a_wrap),
            .wrap_b     (tmr_b_wrap),
            .flag_clear (flag_clear[c]),
            .pin        (cmp_pin[c]),
            .flag       (match_flag[c])
        );
    end

    ocmp_modulator u_mod (
        .carrier  (cmp_pin[0]),
        .envelope (cmp_pin[1]),
        .mod_out  (mod_pin)
    );

    // R2: at most one value is addressed per write
    assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_hit));
endmodule

// File: tb/ocmp_unit_tb.sv
`timescale 1ns/1ps
module ocmp_unit_tb;
    localparam int NCH = 4;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_ptr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [NCH-1:0] ch_enable = '0, ch_use_b = '0, ch_invert = '0, ch_buffered = '0;
    logic [NCH-1:0] port_level = '0, flag_clear = '0;
    logic [CW-1:0] ta_cnt = '0, tb_cnt = '0;
    logic ta_run = 1'b0, tb_run = 1'b0, ta_wrap = 1'b0, tb_wrap = 1'b0;
    logic [CW-1:0] ta_per = 16'd12, tb_per = 16'd7;
    logic [NCH-1:0] cmp_pin, match_flag;
    logic mod_pin;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [CW-1:0] m_stage [NCH][2];
    logic [CW-1:0] m_act   [NCH][2];
    logic          m_lvl   [NCH];
    logic          m_flg   [NCH];

    always #2 clk = ~clk;

    ocmp_unit #(.NCH(NCH), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
        .ch_enable(ch_enable), .ch_use_b(ch_use_b), .ch_invert(ch_invert),
        .ch_buffered(ch_buffered), .port_level(port_level),
        .tmr_a_count(ta_cnt), .tmr_a_running(ta_run), .tmr_a_wrap(ta_wrap),
        .tmr_b_count(tb_cnt), .tmr_b_running(tb_run), .tmr_b_wrap(tb_wrap),
        .flag_clear(flag_clear), .cmp_pin(cmp_pin), .match_flag(match_flag),
        .mod_pin(mod_pin)
    );

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_lvl[c] = 1'b0;
            m_flg[c] = 1'b0;
            for (int k = 0; k < 2; k++) begin
                m_stage[c][k] = '0;
                m_act[c][k]   = '0;
            end
        end
    endtask

    // One clock edge of the expected behaviour, from R2 to R9
    task automatic model_edge();
        for (int c = 0; c < NCH; c++) begin
            logic [CW-1:0] cnt = ch_use_b[c] ? tb_cnt : ta_cnt;
            logic run  = ch_use_b[c] ? tb_run  : ta_run;
            logic wrp  = ch_use_b[c] ? tb_wrap : ta_wrap;
            logic ln   = !run || !ch_buffered[c];
            logic h0   = (cnt == m_act[c][0]);
            logic h1   = (cnt == m_act[c][1]);
            logic nl   = m_lvl[c];
            logic nf   = m_flg[c];
            if (!ch_enable[c]) begin
                nl = 1'b0; nf = 1'b0;
            end else begin
                if (h0) nl = 1'b1; else if (h1) nl = 1'b0;
                if (h0 || h1) nf = 1'b1; else if (flag_clear[c]) nf = 1'b0;
            end
            m_lvl[c] = nl;
            m_flg[c] = nf;
            for (int k = 0; k < 2; k++) begin
                logic hw = wr_en && (wr_ptr == 3'((c << 1) | k));
                logic [CW-1:0] na = m_act[c][k];
                if (hw && ln) na = wr_data;
                else if (wrp) na = m_stage[c][k];
                m_act[c][k] = na;
                if (hw) m_stage[c][k] = wr_data;
            end
        end
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic ep [NCH];
        for (int c = 0; c < NCH; c++) begin
            string tp, tf;
            ep[c] = ch_enable[c] ? (m_lvl[c] ^ ch_invert[c]) : port_level[c];
            if (tag != "") begin
                tp = tag; tf = tag;
            end else begin
                tp = !ch_enable[c] ? "R8" : (ch_invert[c] ? "R7" : "R6");
                tf = !ch_enable[c] ? "R8" : "R9";
            end
            chk(tp, $sformatf("pin%0d", c), cmp_pin[c], ep[c]);
            chk(tf, $sformatf("flag%0d", c), match_flag[c], m_flg[c]);
        end
        chk("R10", "mod_pin", mod_pin, ep[0] & ep[1]);
    endtask

    task automatic tmr_step();
        if (ta_run) begin
            if (ta_cnt == 0) begin ta_cnt = ta_per; ta_wrap = 1'b1; end
            else begin ta_cnt = ta_cnt - 1; ta_wrap = 1'b0; end
        end else ta_wrap = 1'b0;
        if (tb_run) begin
            if (tb_cnt == 0) begin tb_cnt = tb_per; tb_wrap = 1'b1; end
            else begin tb_cnt = tb_cnt - 1; tb_wrap = 1'b0; end
        end else tb_wrap = 1'b0;
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic wr(input logic [2:0] p, input logic [CW-1:0] d, input string tag);
        wr_en = 1'b1; wr_ptr = p; wr_data = d;
        tick(tag);
        wr_en = 1'b0;
        tmr_step();
    endtask

    task automatic run_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick(tag);
            tmr_step();
        end
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        model_reset();
        port_level = 4'b0101;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare_all("R1");

        // R1: zero latches match a stopped count of 0
        ch_enable = 4'b0001;
        run_ticks(2, "R1");

        // R2: pointer picks channel 1 value 0, then value 1
        ch_enable = 4'b0011; ch_use_b = 4'b0010; tb_cnt = 16'h0040;
        wr(3'd2, 16'h0040, "R2");
        run_ticks(2, "R2");
        wr(3'd2, 16'h0010, "R2");
        wr(3'd3, 16'h0040, "R2");
        run_ticks(3, "R2");

        // R3: direct load while the timer runs, period 000C with 000B and 0005
        ch_enable = 4'b0111; ta_run = 1'b1; ta_cnt = 16'h000C; ch_buffered = 4'b0000;
        wr(3'd4, 16'h000B, "R3");
        wr(3'd5, 16'h0005, "R3");
        run_ticks(30, "R3");

        // R4: deferred load on channel 0, including a write in a wrap cycle
        ch_buffered = 4'b1111;
        wr(3'd0, 16'h0003, "R4");
        wr(3'd1, 16'h0009, "R4");
        run_ticks(30, "R4");
        while (ta_cnt != 16'h0000) run_ticks(1, "R4");
        tick("R4"); tmr_step();
        wr(3'd0, 16'h0007, "R4");
        run_ticks(28, "R4");

        // R5: channel 3 on timer B, then moved to timer A
        ch_enable = 4'b1111; tb_run = 1'b1; ch_use_b = 4'b1010;
        wr(3'd6, 16'h0002, "R5");
        wr(3'd7, 16'h0006, "R5");
        run_ticks(20, "R5");
        ch_use_b = 4'b0010;
        run_ticks(20, "R5");

        // R7: inverted pins
        ch_invert = 4'b1111;
        run_ticks(15, "R7");
        ch_invert = 4'b0000;

        // R8: disable mid-waveform, then re-enable
        port_level = 4'b1110;
        ch_enable = 4'b1011;
        run_ticks(10, "R8");
        ch_enable = 4'b1111;
        run_ticks(10, "R8");

        // R9: clears while matches keep arriving
        flag_clear = 4'b1111;
        run_ticks(15, "R9");
        flag_clear = 4'b0000;

        // R6: both values equal, high wins
        wr(3'd0, 16'h0004, "R6");
        wr(3'd1, 16'h0004, "R6");
        run_ticks(30, "R6");

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            wr_en   = ($urandom % 3) == 0;
            wr_ptr  = 3'($urandom);
            wr_data = (($urandom % 8) == 0) ? 16'($urandom) : 16'($urandom % 13);
            if (($urandom % 16) == 0) ch_enable   = 4'($urandom);
            if (($urandom % 16) == 0) ch_use_b    = 4'($urandom);
            if (($urandom % 16) == 0) ch_invert   = 4'($urandom);
            if (($urandom % 16) == 0) ch_buffered = 4'($urandom);
            if (($urandom % 16) == 0) port_level  = 4'($urandom);
            flag_clear = (($urandom % 6) == 0) ? 4'($urandom) : 4'b0000;
            if (($urandom % 40) == 0) ta_run = ~ta_run;
            if (($urandom % 40) == 0) tb_run = ~tb_run;
            tmr_step();
            tick("");
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule